// File: doc/BRIEF.md
# Sixteen-Bit Register-Machine Processor Core

This block is a compact multicycle processor with a 16-bit data word. It has sixteen general registers, where register 0 always reads as zero, an 8-bit program counter and a private 256-word memory that holds both code and data. Every instruction is 16 bits wide. The top nibble selects one of sixteen operations and the next nibble names the destination register. The low byte is either two source-register nibbles or an 8-bit address. Each instruction takes one fetch cycle and one execute cycle. An execute cycle that touches the I/O word can stretch over several cycles.

Word 0xFF is not storage. A load from it takes a value from the input port through a valid/ready handshake. A store to it sends a value to the output port the same way. The indirect forms, which take the address from a register, reach the ports in the same way. A program is written into memory through a load port while reset is held. When reset is released, execution starts at a parameterised start address. The halt opcode stops the core and raises a status output, which stays high until the next reset.

Top module: `r16_core`

## Requirements
- R1: While reset is held and just after it is released, `halted`, `in_ready` and `out_valid` are low. All registers start at zero and the first instruction is fetched from address START (default 0x10).
- R2: Instruction fields: opcode = bits 15:12, d = bits 11:8. The register-register form has s = bits 7:4 and t = bits 3:0. The address form has addr = bits 7:0.
- R3: Opcodes 1 (add), 2 (subtract), 3 (AND) and 4 (XOR) write R[d] = R[s] op R[t], with arithmetic wrapping modulo 2^16.
- R4: Opcode 5 shifts R[s] left and opcode 6 shifts R[s] right logically. The shift amount is the low 4 bits of R[t].
- R5: Register 0 reads as zero, and any write to it is discarded.
- R6: Opcode 7 writes the zero-extended addr field into R[d] and performs no memory access.
- R7: Opcode 8 loads R[d] from mem[addr] and opcode 9 stores R[d] to mem[addr]. A store to an address other than 0xFF produces no output transfer.
- R8: Opcode A loads R[d] from mem[R[t][7:0]] and opcode B stores R[d] to mem[R[t][7:0]]. These indirect forms reach the I/O ports when that address is 0xFF.
- R9: A load from 0xFF holds `in_ready` high and waits until `in_valid` is high. It then writes `in_data` into R[d].
- R10: A store to 0xFF holds `out_valid` high with `out_data` = R[d`] stable until `out_ready` is high. Each transfer is delivered exactly once.
- R11: Opcode C branches to addr when R[d] is zero. Opcode D branches when R[d] is nonzero with bit 15 clear. Otherwise execution falls through.
- R12: Opcode E jumps to R[d][7:0]. Opcode F writes the address after itself into R[d] and then jumps to addr.
- R13: Opcode 0 raises `halted`. From then until reset the core fetches nothing and performs no I/O.
- R14: While `rst_n` is low, a high `ld_we` writes `ld_data` into memory word `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_we | input | 1 | Program-load write strobe (use during reset) |
| ld_addr | input | 8 | Program-load word address |
| ld_data | input | 16 | Program-load data |
| in_data | input | 16 | Input port data |
| in_valid | input | 1 | Input port data valid |
| in_ready | output | 1 | Core is waiting on an input load |
| out_data | output | 16 | Output port data |
| out_valid | output | 1 | Output port data valid |
| out_ready | input | 1 | Receiver accepts output data |
| halted | output | 1 | Halt instruction has executed |

## Verification
All register and memory state becomes visible only through the output port and `halted`. A wrong ALU result, a wrong register index or a lost write therefore shows up as a wrong value in the next output transfer, a few instructions later. A wrong branch or link decision shows up as a missing transfer, an extra transfer or a transfer out of order, within about two cycles per skipped or repeated instruction. Handshake faults show up within one cycle as a dropped `in_ready` or `out_valid`, or as `out_data` changing during a stall.

// File: rtl/r16_pkg.sv
package r16_pkg;
  localparam int unsigned XLEN  = 16;
  localparam int unsigned ALEN  = 8;
  localparam int unsigned NREG  = 16;
  localparam int unsigned RIDX  = $clog2(NREG);
  localparam int unsigned DEPTH = 1 << ALEN;

  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_AND = 4'h3,
    OP_XOR  = 4'h4, OP_SHL = 4'h5, OP_SHR = 4'h6, OP_LDA = 4'h7,
    OP_LD   = 4'h8, OP_ST  = 4'h9, OP_LDI = 4'hA, OP_STI = 4'hB,
    OP_BZ   = 4'hC, OP_BP  = 4'hD, OP_JR  = 4'hE, OP_JAL = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } state_e;
endpackage

// File: rtl/r16_rst_sync.sv
module r16_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/r16_regfile.sv
module r16_regfile #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [IW-1:0] ra_s,
  input  logic [IW-1:0] ra_t,
  input  logic [IW-1:0] ra_d,
  output logic [W-1:0]  rd_s,
  output logic [W-1:0]  rd_t,
  output logic [W-1:0]  rd_d
);
  logic [W-1:0] q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign q[i] = '0;
    end else begin : g_flop
      logic en;
      assign en = we && (wa == IW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q[i] <= '0;
        else if (en) q[i] <= wd;
      end
    end
  end

  assign rd_s = q[ra_s];
  assign rd_t = q[ra_t];
  assign rd_d = q[ra_d];

  // R5
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_d == '0) |-> (rd_d == '0));
endmodule

// File: rtl/r16_alu.sv
module r16_alu
  import r16_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  opcode_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  y
);
  logic [SW-1:0] sh;
  assign sh = b[SW-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/r16_mem.sv
module r16_mem #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] m [DEPTH];

  always_ff @(posedge clk) begin
    if (we) m[wa] <= wd;
  end

  assign rdata = m[ra];
endmodule

// File: rtl/r16_core.sv
module r16_core
  import r16_pkg::*;
#(
  parameter logic [7:0] START   = 8'h10,
  parameter logic [7:0] IO_ADDR = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_we,
  input  logic [7:0]  ld_addr,
  input  logic [15:0] ld_data,
  input  logic [15:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [15:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        halted
);
  logic rst_q_n;
  r16_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  state_e          state, state_n;
  logic [ALEN-1:0] pc, pc_n;
  logic [XLEN-1:0] ir, ir_n;
  logic            pc_en, ir_en, st_en;

  opcode_e         op;
  logic [RIDX-1:0] f_d, f_s, f_t;
  logic [ALEN-1:0] f_addr;
  assign op     = opcode_e'(ir[15:12]);
  assign f_d    = ir[11:8];
  assign f_s    = ir[7:4];
  assign f_t    = ir[3:0];
  assign f_addr = ir[7:0];

  logic            rf_we;
  logic [XLEN-1:0] rf_wd, v_s, v_t, v_d, alu_y;

  r16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_q_n), .we(rf_we), .wa(f_d), .wd(rf_wd),
    .ra_s(f_s), .ra_t(f_t), .ra_d(f_d),
    .rd_s(v_s), .rd_t(v_t), .rd_d(v_d));

  r16_alu #(.W(XLEN)) u_alu (.op(op), .a(v_s), .b(v_t), .y(alu_y));

  logic            indirect, is_io, core_we;
  logic [ALEN-1:0] eaddr, mem_ra, mem_wa;
  logic [XLEN-1:0] mem_rd, mem_wd;
  logic            mem_we;

  assign indirect = (op == OP_LDI) || (op == OP_STI);
  assign eaddr    = indirect ? v_t[ALEN-1:0] : f_addr;
  assign is_io    = (eaddr == IO_ADDR);
  assign mem_ra   = (state == ST_FETCH) ? pc : eaddr;
  assign mem_we   = ld_we || core_we;
  assign mem_wa   = ld_we ? ld_addr : eaddr;
  assign mem_wd   = ld_we ? ld_data : v_d;

  r16_mem #(.W(XLEN), .AW(ALEN)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(mem_ra), .rdata(mem_rd));

  logic bp_take;
  assign bp_take = !v_d[XLEN-1] && (v_d != '0);

  always_comb begin
    state_n   = state;
    pc_n      = pc;
    ir_n      = ir;
    rf_we     = 1'b0;
    rf_wd     = alu_y;
    core_we   = 1'b0;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    unique case (state)
      ST_FETCH: begin
        ir_n    = mem_rd;
        pc_n    = pc + 1'b1;
        state_n = ST_EXEC;
      end
      ST_EXEC: begin
        state_n = ST_FETCH;
        unique case (op)
          OP_HALT: state_n = ST_HALT;
          OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: rf_we = 1'b1;
          OP_LDA: begin
            rf_we = 1'b1;
            rf_wd = {{(XLEN-ALEN){1'b0}}, f_addr};
          end
          OP_LD, OP_LDI: begin
            if (is_io) begin
              in_ready = 1'b1;
              rf_we    = in_valid;
              rf_wd    = in_data;
              if (!in_valid) state_n = ST_EXEC;
            end else begin
              rf_we = 1'b1;
              rf_wd = mem_rd;
            end
          end
          OP_ST, OP_STI: begin
            if (is_io) begin
              out_valid = 1'b1;
              if (!out_ready) state_n = ST_EXEC;
            end else begin
              core_we = 1'b1;
            end
          end
          OP_BZ:  if (v_d == '0) pc_n = f_addr;
          OP_BP:  if (bp_take)   pc_n = f_addr;
          OP_JR:  pc_n = v_d[ALEN-1:0];
          OP_JAL: begin
            rf_we = 1'b1;
            rf_wd = {{(XLEN-ALEN){1'b0}}, pc};
            pc_n  = f_addr;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign pc_en = (state_n != state) || (pc_n != pc);
  assign ir_en = (state == ST_FETCH);
  assign st_en = (state != ST_HALT);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state <= ST_FETCH;
      pc    <= START;
      ir    <= '0;
    end else begin
      if (st_en) state <= state_n;
      if (pc_en) pc    <= pc_n;
      if (ir_en) ir    <= ir_n;
    end
  end

  assign out_data = out_valid ? v_d : '0;
  assign halted   = (state == ST_HALT);

  // R13
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    halted |=> halted);
  // R13
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    halted |-> (!in_ready && !out_valid));
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  in_wait_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_ready && !in_valid) |=> in_ready);
  // R9
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(in_ready && out_valid));
  // R14
  no_core_write_in_reset_chk: assert property (@(posedge clk)
    !rst_q_n |-> !core_we);
endmodule

// File: tb/tb_r16_core.sv
module tb_r16_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] in_data;
  logic        in_valid = 1'b1;
  logic        in_ready;
  logic [15:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        halted;

  int checks = 0;
  int errors = 0;

  logic [15:0] in_q [8];
  int          in_idx;
  logic [15:0] out_log [8];
  int          n_out;

  always #(CLK_P/2) clk = ~clk;

  r16_core dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .halted(halted));

  assign in_data = in_q[in_idx[2:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_idx <= 0;
      n_out  <= 0;
    end else begin
      if (in_ready && in_valid) in_idx <= in_idx + 1;
      if (out_valid && out_ready) begin
        out_log[n_out[2:0]] <= out_data;
        n_out <= n_out + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic begin_load();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) in_q[i] = 16'h0000;
  endtask

  task automatic prog(input logic [7:0] a, input logic [15:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic go(input string tag);
    int n;
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " halted"}, 16'(halted), 16'h0001);
  endtask

  localparam logic [63:0] VEC [8] = '{
    {16'h1, 16'h1234, 16'h0F0F, 16'h2143},
    {16'h1, 16'hFFFF, 16'h0002, 16'h0001},
    {16'h2, 16'h0005, 16'h0007, 16'hFFFE},
    {16'h3, 16'hF0F0, 16'h3C3C, 16'h3030},
    {16'h4, 16'hAAAA, 16'h0FF0, 16'hA55A},
    {16'h5, 16'h0001, 16'h0013, 16'h0008},
    {16'h6, 16'h8000, 16'h0004, 16'h0800},
    {16'h6, 16'h8000, 16'h0010, 16'h8000}
  };

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state and R13 halt at start address
    begin_load();
    prog(8'h10, 16'h0000);
    check("R1 halted in reset", 16'(halted), 16'h0000);
    check("R1 out_valid in reset", 16'(out_valid), 16'h0000);
    check("R1 in_ready in reset", 16'(in_ready), 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 halted after release", 16'(halted), 16'h0000);
    go("R13 start");
    check("R13 no output", 16'(n_out), 16'h0000);

    // R2 R3 R4: table walked by one loop
    for (int v = 0; v < 8; v++) begin
      begin_load();
      prog(8'h10, 16'h81FF);
      prog(8'h11, 16'h82FF);
      prog(8'h12, {VEC[v][51:48], 12'h312});
      prog(8'h13, 16'h93FF);
      prog(8'h14, 16'h0000);
      in_q[0] = VEC[v][47:32];
      in_q[1] = VEC[v][31:16];
      go("R3 alu");
      check("R3 R4 alu count", 16'(n_out), 16'h0001);
      check(v < 5 ? "R3 alu result" : "R4 shift result", out_log[0], VEC[v][15:0]);
    end

    // R5 register 0
    begin_load();
    prog(8'h10, 16'h80FF);
    prog(8'h11, 16'h90FF);
    prog(8'h12, 16'h0000);
    in_q[0] = 16'h5555;
    go("R5");
    check("R5 r0 reads zero", out_log[0], 16'h0000);

    // R6 load address, R7 direct memory
    begin_load();
    prog(8'h10, 16'h74AB);
    prog(8'h11, 16'h94FF);
    prog(8'h12, 16'h82FF);
    prog(8'h13, 16'h9240);
    prog(8'h14, 16'h8340);
    prog(8'h15, 16'h93FF);
    prog(8'h16, 16'h0000);
    in_q[0] = 16'hBEEF;
    go("R6 R7");
    check("R6 zero-extended", out_log[0], 16'h00AB);
    check("R7 store/load mem", out_log[1], 16'hBEEF);
    check("R7 plain store silent", 16'(n_out), 16'h0002);

    // R8 indirect forms
    begin_load();
    prog(8'h10, 16'h75FF);
    prog(8'h11, 16'hA605);
    prog(8'h12, 16'h7740);
    prog(8'h13, 16'hB607);
    prog(8'h14, 16'hA807);
    prog(8'h15, 16'hB805);
    prog(8'h16, 16'h0000);
    in_q[0] = 16'h1357;
    go("R8");
    check("R8 indirect io", out_log[0], 16'h1357);
    check("R8 count", 16'(n_out), 16'h0001);

    // R11 branches, three inputs for branch positive
    for (int k = 0; k < 3; k++) begin
      begin_load();
      prog(8'h10, 16'h7100);
      prog(8'h11, 16'hC114);
      prog(8'h12, 16'h72EE);
      prog(8'h13, 16'h92FF);
      prog(8'h14, 16'h7233);
      prog(8'h15, 16'h92FF);
      prog(8'h16, 16'h83FF);
      prog(8'h17, 16'hD31A);
      prog(8'h18, 16'h7344);
      prog(8'h19, 16'h93FF);
      prog(8'h1A, 16'h0000);
      in_q[0] = (k == 0) ? 16'h8001 : (k == 1) ? 16'h0001 : 16'h0000;
      go("R11");
      check("R11 bz taken", out_log[0], 16'h0033);
      check("R11 bp decision count", 16'(n_out), (k == 1) ? 16'h0001 : 16'h0002);
    end

    // R12 jump-and-link, jump register
    begin_load();
    prog(8'h10, 16'hF520);
    prog(8'h11, 16'h95FF);
    prog(8'h12, 16'h0000);
    prog(8'h20, 16'h7E99);
    prog(8'h21, 16'h9EFF);
    prog(8'h22, 16'hE500);
    go("R12");
    check("R12 subroutine", out_log[0], 16'h0099);
    check("R12 link value", out_log[1], 16'h0011);

    // R9 R10 stalls
    begin_load();
    prog(8'h10, 16'h81FF);
    prog(8'h11, 16'h91FF);
    prog(8'h12, 16'h0000);
    in_q[0] = 16'hC0DE;
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 in_ready waiting", 16'(in_ready), 16'h0001);
    check("R9 no progress", 16'(out_valid), 16'h0000);
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 out_valid held", 16'(out_valid), 16'h0001);
    repeat (6) @(negedge clk);
    check("R10 still valid", 16'(out_valid), 16'h0001);
    check("R10 out_data", out_data, 16'hC0DE);
    check("R10 not yet taken", 16'(n_out), 16'h0000);
    out_ready = 1'b1;
    go("R10");
    check("R10 single transfer", 16'(n_out), 16'h0001);
    check("R9 one input taken", 16'(in_idx), 16'h0001);

    // R13 halt holds
    repeat (20) @(negedge clk);
    check("R13 halt stays", 16'(halted), 16'h0001);
    check("R13 no io after halt", 16'(in_ready | out_valid), 16'h0000);
    check("R13 no new output", 16'(n_out), 16'h0001);

    // R14 load port writes during reset only observed by program run above;
    // reload while reset held and confirm new contents execute
    begin_load();
    prog(8'h10, 16'h7177);
    prog(8'h11, 16'h91FF);
    prog(8'h12, 16'h0000);
    go("R14");
    check("R14 reloaded program", out_log[0], 16'h0077);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule